// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block moves one 8-bit companded PCM sample in each direction across a synchronous serial line. The bit clock, the frame strobe and the serial input arrive asynchronously to the block's system clock. They are resynchronised and edge-detected there. An active-high strobe marks the timeslot, which repeats at an 8 kHz frame rate. The transmit byte leaves most significant bit first, one bit for each bit-clock rising edge. The receive byte is gathered most significant bit first on the bit-clock falling edges.

Toward the codec, the transmit side is a valid/ready stream into a one-byte holding register. A byte is accepted on any cycle where `tx_valid` and `tx_ready` are both high. While the register is full, `tx_ready` stays low and the producer must hold `tx_valid` and `tx_data` steady. The holding register is emptied into the shifter at the start of each timeslot. The receive side cannot stall, because the serial line never waits, so it has no ready signal. The consumer must take `rx_data` in the cycle where `rx_valid` is high.

Two mute controls can replace a byte with the negative-zero code of the selected companding law. The same code fills the line when no transmit byte was supplied in time. The serial output is driven only inside the timeslot, and an enable is provided for an external tri-state pad.

Top module: `pcm_strobe_port`

## Requirements
- R1: While `rst_n` is low and after it is released, `sdout_oe`, `sdout` and `rx_valid` are 0 and `tx_ready` is 1.
- R2: `sdout_oe` rises a few system cycles after the strobe rises and falls a few cycles after the strobe falls. While `sdout_oe` is 0, `sdout` is 0.
- R3: The first transmit bit (bit 7) appears after the bit-clock rising edge that coincides with the strobe rise. Each following rising edge inside the window presents the next lower bit, down to bit 0. The line then holds bit 0 until the window closes.
- R4: On the first 8 bit-clock falling edges inside the window, `sdin` is sampled MSB first. A single one-cycle `rx_valid` pulse then presents the assembled byte on `rx_data`.
- R5: If `tx_mute` is 1 when the strobe rise is detected, the transmitted byte is the negative-zero code: 8'h7F when `law_a` is 0 (µ-law) and 8'h55 when `law_a` is 1 (A-law). Any held byte is discarded.
- R6: If `rx_mute` is 1 when the 8th sample is taken, `rx_data` carries the negative-zero code of the current `law_a` (8'h7F or 8'h55) instead of the sampled byte.
- R7: A byte accepted through `tx_valid`/`tx_ready` is the one sent in the next timeslot.
- R8: In the cycle where a timeslot takes the held byte, `tx_ready` is 1 even though the register was full. A byte offered in that cycle is accepted and sent in the following timeslot, and no byte is lost or repeated.
- R9: If the holding register is empty when a timeslot opens, the negative-zero code of the current law is sent.
- R10: Falling edges after the 8th inside one window, and all bit-clock activity outside the window, produce no further `rx_valid`.
- R11: While the holding register is full and no timeslot is opening, `tx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset, clears all state |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| strobe | input | 1 | Active-high timeslot strobe |
| sdin | input | 1 | Serial receive data |
| law_a | input | 1 | Companding law: 1 A-law, 0 µ-law |
| tx_mute | input | 1 | Replace the transmit byte with negative zero |
| rx_mute | input | 1 | Replace the received byte with negative zero |
| tx_data | input | 8 | Transmit byte from the codec |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register can accept a byte |
| rx_data | output | 8 | Received byte toward the codec |
| rx_valid | output | 1 | One-cycle pulse, `rx_data` valid |
| sdout | output | 1 | Serial transmit data (0 when not driven) |
| sdout_oe | output | 1 | Output enable for the tri-state serial pad |

## Verification
The two functions that can fall in the same cycle are the timeslot load, which empties the holding register into the shifter, and the stream handshake, which refills it. The bench fills the register with one byte and then holds a second byte on `tx_valid` while a frame starts. The acceptance then lands exactly on the load cycle. The result is judged on the line: that frame must carry the first byte, the next frame the second, and `tx_ready` must read 0 in between.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned PCM_W = 8;
  typedef logic [PCM_W-1:0] pcm_t;

  localparam pcm_t NZ_MU_LAW = 8'h7F;
  localparam pcm_t NZ_A_LAW  = 8'h55;

  // Silence code for the selected companding law.
  function automatic pcm_t neg_zero(input logic law_a);
    return law_a ? NZ_A_LAW : NZ_MU_LAW;
  endfunction
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0][STAGES-1:0] chain;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= {chain[i][STAGES-2:0], async_in[i]};
    end
    assign sync_out[i] = chain[i][STAGES-1];
  end
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int unsigned W = PCM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         close,
  input  logic         law_a,
  input  logic         tx_mute,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         sdout,
  output logic         sdout_oe,
  output logic [W-1:0] word
);
  localparam int unsigned SW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  hold, shreg;
  logic          hold_full, active;
  logic [SW-1:0] nsh;
  logic          accept;

  // The slot frees the holding register in the load cycle itself.
  assign tx_ready = !hold_full || load;
  assign accept   = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold      <= tx_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      nsh    <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= (tx_mute || !hold_full) ? W'(neg_zero(law_a)) : hold;
      nsh    <= '0;
      active <= 1'b1;
    end else if (close) begin
      active <= 1'b0;
    end else if (shift && active && nsh != SW'(W-1)) begin
      shreg <= {shreg[W-2:0], 1'b0};
      nsh   <= nsh + 1'b1;
    end
  end

  assign sdout    = active && shreg[W-1];
  assign sdout_oe = active;
  assign word     = shreg;
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
#(
  parameter int unsigned W = PCM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic         sample,
  input  logic         window,
  input  logic         din,
  input  logic         law_a,
  input  logic         rx_mute,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] nbits;
  logic [W-1:0]  next_word;

  assign next_word = {sreg[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg     <= '0;
      nbits    <= CW'(W);
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (open) begin
        nbits <= '0;
      end else if (sample && window && nbits != CW'(W)) begin
        sreg  <= next_word;
        nbits <= nbits + 1'b1;
        if (nbits == CW'(W-1)) begin
          rx_data  <= rx_mute ? W'(neg_zero(law_a)) : next_word;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             strobe,
  input  logic             sdin,
  input  logic             law_a,
  input  logic             tx_mute,
  input  logic             rx_mute,
  input  logic [PCM_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [PCM_W-1:0] rx_data,
  output logic             rx_valid,
  output logic             sdout,
  output logic             sdout_oe
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] synced;
  logic             bclk_s, strb_s, din_s;
  logic             bclk_d, strb_d;
  logic             bclk_rise, bclk_fall, strb_rise, strb_fall;
  logic [PCM_W-1:0] tx_word;

  pcm_in_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sdin, strobe, bclk}),
    .sync_out (synced)
  );

  assign bclk_s = synced[0];
  assign strb_s = synced[1];
  assign din_s  = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      strb_d <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      strb_d <= strb_s;
    end
  end

  assign bclk_rise = bclk_s && !bclk_d;
  assign bclk_fall = !bclk_s && bclk_d;
  assign strb_rise = strb_s && !strb_d;
  assign strb_fall = !strb_s && strb_d;

  pcm_tx_path #(.W(PCM_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (strb_rise),
    .shift    (bclk_rise),
    .close    (strb_fall),
    .law_a    (law_a),
    .tx_mute  (tx_mute),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .sdout    (sdout),
    .sdout_oe (sdout_oe),
    .word     (tx_word)
  );

  pcm_rx_path #(.W(PCM_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .open     (strb_rise),
    .sample   (bclk_fall),
    .window   (strb_s),
    .din      (din_s),
    .law_a    (law_a),
    .rx_mute  (rx_mute),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );
endmodule

// File: rtl/pcm_strobe_port_chk.sv
module pcm_strobe_port_chk
  import pcm_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_win,
  input logic             sdout,
  input logic             sdout_oe,
  input logic             rx_valid,
  input logic [PCM_W-1:0] rx_data,
  input logic             rx_mute,
  input logic             tx_mute,
  input logic             law_a,
  input logic [PCM_W-1:0] tx_word
);
  // R2: line is quiet whenever the pad is not enabled
  assert_quiet_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdout_oe |-> !sdout);

  // R2: once the window has closed the driver lets go on the next cycle
  assert_release_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sdout_oe && !strobe_win) |=> !sdout_oe);

  // R4: received byte is announced for exactly one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: muted receive carries the law's negative-zero code
  assert_rx_mute_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(rx_mute)) |-> rx_data == neg_zero($past(law_a)));

  // R5: muted transmit slot is loaded with the law's negative-zero code
  assert_tx_mute_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdout_oe) && $past(tx_mute)) |-> tx_word == neg_zero($past(law_a)));
endmodule

bind pcm_strobe_port pcm_strobe_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_win (strb_s),
  .sdout      (sdout),
  .sdout_oe   (sdout_oe),
  .rx_valid   (rx_valid),
  .rx_data    (rx_data),
  .rx_mute    (rx_mute),
  .tx_mute    (tx_mute),
  .law_a      (law_a),
  .tx_word    (tx_word)
);

// File: tb/pcm_strobe_port_test.sv
module pcm_strobe_port_test;
  localparam int HB = 8;  // system cycles per half bit period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0, strobe = 1'b0, sdin = 1'b0;
  logic       law_a = 1'b0, tx_mute = 1'b0, rx_mute = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       sdout, sdout_oe;

  int checks = 0;
  int errors = 0;
  int rx_seen = 0;
  logic [7:0] rx_last = 8'h00;

  always #10 clk = ~clk;

  pcm_strobe_port uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .strobe(strobe), .sdin(sdin),
    .law_a(law_a), .tx_mute(tx_mute), .rx_mute(rx_mute),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sdout(sdout), .sdout_oe(sdout_oe)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_seen = rx_seen + 1;
      rx_last = rx_data;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nz(input logic a);
    return a ? 8'h55 : 8'h7F;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // One timeslot of nrise bit periods, then two idle periods with noise on sdin.
  task automatic run_frame(input logic [7:0] rxb, input int nrise,
                           output logic [7:0] txb, output logic oe_ok);
    txb   = 8'h00;
    oe_ok = 1'b1;
    repeat (HB) @(negedge clk);
    bclk = 1'b1; strobe = 1'b1; sdin = rxb[7];
    for (int i = 0; i < nrise; i++) begin
      repeat (HB) @(negedge clk);
      bclk = 1'b0;
      if (i < 8) txb[7-i] = sdout;
      if (!sdout_oe) oe_ok = 1'b0;
      repeat (HB) @(negedge clk);
      bclk = 1'b1;
      if (i == nrise - 1) strobe = 1'b0;
      sdin = (i + 1 < 8) ? rxb[6-i] : ~sdin;
    end
    for (int g = 0; g < 2; g++) begin
      repeat (HB) @(negedge clk);
      bclk = 1'b0; sdin = ~sdin;
      repeat (HB) @(negedge clk);
      bclk = 1'b1; sdin = ~sdin;
    end
    repeat (HB) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 oe in reset", {7'd0, sdout_oe}, 8'd0);
    check("R1 sdout in reset", {7'd0, sdout}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rx_valid after reset", {7'd0, rx_valid}, 8'd0);
    check("R1 tx_ready after reset", {7'd0, tx_ready}, 8'd1);
    check("R1 oe after reset", {7'd0, sdout_oe}, 8'd0);
  endtask

  task automatic t_exchange(input logic [7:0] txv, input logic [7:0] rxv);
    logic [7:0] got; logic ok; int n0;
    push(txv);
    check("R11 ready low while held", {7'd0, tx_ready}, 8'd0);
    n0 = rx_seen;
    run_frame(rxv, 8, got, ok);
    check("R3/R7 transmitted byte", got, txv);
    check("R4 one valid pulse", 8'(rx_seen - n0), 8'd1);
    check("R4 received byte", rx_last, rxv);
    check("R2 oe held in window", {7'd0, ok}, 8'd1);
    check("R2 oe released after window", {7'd0, sdout_oe}, 8'd0);
    check("R2 line quiet after window", {7'd0, sdout}, 8'd0);
  endtask

  task automatic t_tx_mute;
    logic [7:0] got; logic ok;
    tx_mute = 1'b1;
    for (int l = 0; l < 2; l++) begin
      law_a = l[0];
      push(8'h12);
      run_frame(8'h00, 8, got, ok);
      check("R5 muted transmit code", got, nz(l[0]));
      check("R5 held byte discarded", {7'd0, tx_ready}, 8'd1);
    end
    tx_mute = 1'b0; law_a = 1'b0;
  endtask

  task automatic t_rx_mute;
    logic [7:0] got; logic ok; int n0;
    rx_mute = 1'b1;
    for (int l = 0; l < 2; l++) begin
      law_a = l[0];
      n0 = rx_seen;
      run_frame(8'hC3, 8, got, ok);
      check("R6 muted receive pulse", 8'(rx_seen - n0), 8'd1);
      check("R6 muted receive code", rx_last, nz(l[0]));
    end
    rx_mute = 1'b0; law_a = 1'b0;
  endtask

  task automatic t_underrun;
    logic [7:0] got; logic ok;
    for (int l = 0; l < 2; l++) begin
      law_a = l[0];
      run_frame(8'h5A, 8, got, ok);
      check("R9 underrun fill code", got, nz(l[0]));
    end
    law_a = 1'b0;
  endtask

  task automatic t_same_cycle;
    logic [7:0] got1, got2; logic ok;
    push(8'hC6);
    check("R11 ready low before slot", {7'd0, tx_ready}, 8'd0);
    fork
      run_frame(8'h11, 8, got1, ok);
      push(8'h39);
    join
    check("R8 ready low after refill", {7'd0, tx_ready}, 8'd0);
    check("R8 first slot byte", got1, 8'hC6);
    run_frame(8'h22, 8, got2, ok);
    check("R8 refilled byte in next slot", got2, 8'h39);
    check("R8 register empty afterwards", {7'd0, tx_ready}, 8'd1);
  endtask

  task automatic t_long_window;
    logic [7:0] got; logic ok; int n0;
    push(8'hE1);
    n0 = rx_seen;
    run_frame(8'h96, 10, got, ok);
    check("R10 single pulse in long window", 8'(rx_seen - n0), 8'd1);
    check("R10 first eight bits kept", rx_last, 8'h96);
    check("R3 long window transmit", got, 8'hE1);
    n0 = rx_seen;
    for (int k = 0; k < 4; k++) begin
      repeat (HB) @(negedge clk); bclk = 1'b1; sdin = ~sdin;
      repeat (HB) @(negedge clk); bclk = 1'b0;
    end
    repeat (HB) @(negedge clk);
    check("R10 no pulse outside window", 8'(rx_seen - n0), 8'd0);
    check("R2 no drive outside window", {7'd0, sdout_oe}, 8'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    t_exchange(8'hA5, 8'h3C);
    t_exchange(8'h01, 8'h80);
    t_exchange(8'hFE, 8'h7E);
    t_tx_mute;
    t_rx_mute;
    t_underrun;
    t_same_cycle;
    t_long_window;
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule